// File: doc/BRIEF.md
# Chainable Event Counter Bank

This block is a bank of eight 32-bit event counters that watches one cache slice. Each counter has an 8-bit selector. The selector picks either a free-running cycle count or one of six one-bit event pulses: read hit, read miss, data-side read hit, data-side read miss, write hit and write miss. Software drives the bank through a 32-bit memory-mapped bus. It sets and clears the counter enables and the interrupt enables with separate write-one-to-set and write-one-to-clear registers. It reads the pending overflow flags and clears them by writing ones back. It can also preload any counter at any time.

An even/odd pair can be linked into a 64-bit counter. When the link bit of the odd member is set, the odd counter stops counting its own event. It then advances on every carry out of its even partner, so the odd counter holds the upper half. A per-counter option raises the overflow flag whenever bit 31 changes value. This lets software leave a 32-bit counter free-running and still take an interrupt every 2^31 events. A single level interrupt is high while any flagged counter also has its interrupt enabled.

Top module: `evcnt_bank`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The selector register of counter n is at 0x220+8n, and a read returns its low 8 bits. Code 0x01 counts every cycle. Codes 0x20 to 0x25 count `ev_in[0]` to `ev_in[5]`, one per cycle in which the bit is high. Every other code counts nothing.
- R3: A counter advances only while bit 0 of the global register (0x500) is 1 and its own enable bit is 1. Writing 1s to 0x508 sets enable bits and writing 1s to 0x50C clears them, with bit n for counter n. Both addresses read back the enable mask. Bit 0 of 0x500 reads back as the global enable.
- R4: The count register of counter n is at 0x420+8n. A write to it loads the written value and takes priority over an increment in the same cycle. A read returns the value held before that cycle's increment.
- R5: A counter that steps from 0xFFFFFFFF to 0 sets its bit in the overflow register (0x740). Writing a 1 to a bit of 0x740 clears that bit, and a new overflow in the same cycle wins over the clear.
- R6: `irq` is high exactly while some counter has both its overflow bit and its interrupt-enable bit set. Interrupt enables are set through 0x510 and cleared through 0x514, and both addresses read the mask.
- R7: When bit k+1 (odd) of the link register (0x718) is set, counter k+1 advances in the same cycle that counter k wraps, and never on its own event. Link bits at even positions are stored but have no effect.
- R8: In a linked pair, the even counter still flags its own wrap, and the odd counter flags its own 32-bit wrap.
- R9: When bit n of the toggle register (0x96C) is set, an increment that changes bit 31 of counter n sets its overflow bit. With the bit clear, only the wrap does.
- R10: Writing 0x500 with bit 1 set clears all counts and overflow flags in that cycle. Bit 0 of the same write still loads the global enable, and bit 1 reads back as 0.
- R11: A read request is always accepted (`bus_ready` high). `bus_rvalid` and `bus_rdata` follow one cycle later. Unmapped addresses and the per-counter control registers (0x120+8n) read as zero, and writes to the control registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| ev_in | input | 6 | Event pulses, one bit per event kind |
| irq | output | 1 | Level interrupt |

## Verification
The event pulses are random in every cycle. Each counter runs under a different selector, including an undefined code and zero, so a miscounted or mismatched event source shows up as a count difference. Preloads put counters a few steps below 0xFFFFFFFF and below 0x80000000. These runs tell a plain wrap apart from a bit-31 toggle, a linked carry apart from the odd counter's own event, and an odd-half wrap apart from an even-half wrap. Enable-mask and global-enable changes made while events keep arriving separate gating errors from count errors. Clears issued while a counter is about to overflow test the set-over-clear ordering.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int unsigned A_CNT_BASE = 32'h420;
  localparam int unsigned A_CTL_BASE = 32'h120;
  localparam int unsigned A_SEL_BASE = 32'h220;
  localparam int unsigned A_GCTL     = 32'h500;
  localparam int unsigned A_ENSET    = 32'h508;
  localparam int unsigned A_ENCLR    = 32'h50C;
  localparam int unsigned A_IESET    = 32'h510;
  localparam int unsigned A_IECLR    = 32'h514;
  localparam int unsigned A_LINK     = 32'h718;
  localparam int unsigned A_OVF      = 32'h740;
  localparam int unsigned A_TOGGLE   = 32'h96C;
  localparam int unsigned STRIDE     = 8;
  localparam logic [7:0] CODE_CYCLES = 8'h01;
  localparam logic [7:0] CODE_EV0    = 8'h20;
endpackage

// File: rtl/evcnt_evsel.sv
module evcnt_evsel
  import evcnt_pkg::*;
#(
  parameter int NUM_EV = 6
) (
  input  logic [7:0]        sel,
  input  logic [NUM_EV-1:0] ev,
  output logic              hit
);
  always_comb begin
    hit = (sel == CODE_CYCLES);
    for (int i = 0; i < NUM_EV; i++) begin
      if (sel == CODE_EV0 + 8'(i)) hit = hit | ev[i];
    end
  end
endmodule

// File: rtl/evcnt_slice.sv
module evcnt_slice #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         inc,
  input  logic         msb_mode,
  output logic [W-1:0] value,
  output logic         carry,
  output logic         flag
);
  logic low_full;
  logic live;

  assign low_full = &value[W-2:0];
  assign live     = inc & ~wr & ~clr;
  // the top bit flips exactly when all lower bits are ones
  assign carry    = live & low_full & value[W-1];
  assign flag     = live & low_full & (value[W-1] | msb_mode);

  always_ff @(posedge clk) begin
    if (rst || clr)  value <= '0;
    else if (wr)     value <= wdata;
    else if (inc)    value <= value + W'(1);
  end

  p_write_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && !clr) |=> value == $past(wdata));
  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    (inc && !wr && !clr) |=> value == $past(value) + W'(1));
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!inc && !wr && !clr) |=> $stable(value));
endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
  import evcnt_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int NUM_EV  = 6,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ready,
  output logic              bus_rvalid,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_EV-1:0] ev_in,
  output logic              irq
);
  localparam int IW   = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam int SPAN = NUM_CNT * STRIDE;

  logic wr, rd;
  assign wr        = bus_valid & bus_write;
  assign rd        = bus_valid & ~bus_write;
  assign bus_ready = 1'b1;

  logic [ADDR_W-1:0] off_cnt, off_sel, off_ctl;
  logic              hit_cnt, hit_sel, hit_ctl;
  logic [IW-1:0]     idx_cnt, idx_sel;
  assign off_cnt = bus_addr - ADDR_W'(A_CNT_BASE);
  assign off_sel = bus_addr - ADDR_W'(A_SEL_BASE);
  assign off_ctl = bus_addr - ADDR_W'(A_CTL_BASE);
  assign hit_cnt = (off_cnt < ADDR_W'(SPAN)) && (off_cnt[2:0] == 3'd0);
  assign hit_sel = (off_sel < ADDR_W'(SPAN)) && (off_sel[2:0] == 3'd0);
  assign hit_ctl = (off_ctl < ADDR_W'(SPAN)) && (off_ctl[2:0] == 3'd0);
  assign idx_cnt = off_cnt[IW+2:3];
  assign idx_sel = off_sel[IW+2:3];

  logic wr_gctl, wr_ovf, clr_all;
  assign wr_gctl = wr && bus_addr == ADDR_W'(A_GCTL);
  assign wr_ovf  = wr && bus_addr == ADDR_W'(A_OVF);
  assign clr_all = wr_gctl && bus_wdata[1];

  logic               g_en;
  logic [NUM_CNT-1:0] en_m, ie_m, link_m, tog_m, ovf_m;
  logic [7:0]         sel_r [NUM_CNT];
  logic [DATA_W-1:0]  cnt_v [NUM_CNT];
  logic [NUM_CNT-1:0] ev_hit, inc, carry, flag;

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    logic src;
    logic cnt_wr;
    evcnt_evsel #(.NUM_EV(NUM_EV)) u_sel (
      .sel(sel_r[n]), .ev(ev_in), .hit(ev_hit[n]));
    if (n % 2 == 1) begin : g_odd
      assign src = link_m[n] ? carry[n-1] : ev_hit[n];
    end else begin : g_even
      assign src = ev_hit[n];
    end
    assign inc[n]  = g_en & en_m[n] & src;
    assign cnt_wr  = wr & hit_cnt & (idx_cnt == IW'(n));
    evcnt_slice #(.W(DATA_W)) u_slice (
      .clk(clk), .rst(rst), .clr(clr_all), .wr(cnt_wr), .wdata(bus_wdata),
      .inc(inc[n]), .msb_mode(tog_m[n]), .value(cnt_v[n]),
      .carry(carry[n]), .flag(flag[n]));

    always_ff @(posedge clk) begin
      if (rst) sel_r[n] <= '0;
      else if (wr && hit_sel && idx_sel == IW'(n)) sel_r[n] <= bus_wdata[7:0];
    end
  end

  logic [NUM_CNT-1:0] wmask;
  assign wmask = bus_wdata[NUM_CNT-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      g_en <= 1'b0; en_m <= '0; ie_m <= '0; link_m <= '0; tog_m <= '0; ovf_m <= '0;
    end else begin
      if (wr_gctl) g_en <= bus_wdata[0];
      if (wr && bus_addr == ADDR_W'(A_ENSET))  en_m   <= en_m | wmask;
      if (wr && bus_addr == ADDR_W'(A_ENCLR))  en_m   <= en_m & ~wmask;
      if (wr && bus_addr == ADDR_W'(A_IESET))  ie_m   <= ie_m | wmask;
      if (wr && bus_addr == ADDR_W'(A_IECLR))  ie_m   <= ie_m & ~wmask;
      if (wr && bus_addr == ADDR_W'(A_LINK))   link_m <= wmask;
      if (wr && bus_addr == ADDR_W'(A_TOGGLE)) tog_m  <= wmask;
      if (clr_all)     ovf_m <= '0;
      else if (wr_ovf) ovf_m <= (ovf_m & ~wmask) | flag;
      else             ovf_m <= ovf_m | flag;
    end
  end

  logic [DATA_W-1:0] rmux;
  always_comb begin
    rmux = '0;
    if (hit_cnt)      rmux = cnt_v[idx_cnt];
    else if (hit_sel) rmux = DATA_W'(sel_r[idx_sel]);
    else if (hit_ctl) rmux = '0;
    else begin
      case (bus_addr)
        ADDR_W'(A_GCTL):                   rmux = DATA_W'(g_en);
        ADDR_W'(A_ENSET), ADDR_W'(A_ENCLR): rmux = DATA_W'(en_m);
        ADDR_W'(A_IESET), ADDR_W'(A_IECLR): rmux = DATA_W'(ie_m);
        ADDR_W'(A_LINK):                   rmux = DATA_W'(link_m);
        ADDR_W'(A_OVF):                    rmux = DATA_W'(ovf_m);
        ADDR_W'(A_TOGGLE):                 rmux = DATA_W'(tog_m);
        default:                           rmux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      bus_rdata  <= rd ? rmux : '0;
    end
  end

  assign irq = |(ovf_m & ie_m);

  p_rvalid_follows_r11: assert property (@(posedge clk) disable iff (rst)
    rd |=> bus_rvalid);
  p_no_stray_rvalid_r11: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !bus_rvalid);
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (!wr_ovf && !clr_all) |=> ((ovf_m & $past(ovf_m)) == $past(ovf_m)));
  p_clear_all_r10: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (ovf_m == '0) && (cnt_v[0] == '0));
endmodule

// File: tb/evcnt_bank_tb_top.sv
module evcnt_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, bus_rvalid, irq;
  logic [31:0] bus_rdata;
  logic [5:0]  ev_in = '0;

  always #5 clk = ~clk;

  evcnt_bank dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .ev_in(ev_in), .irq(irq));

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // behavioural reference
  logic [31:0] m_cnt [8];
  logic [7:0]  m_sel [8];
  logic [7:0]  m_en, m_ie, m_link, m_tog, m_ovf;
  logic        m_gen, m_rv;
  logic [31:0] m_rd;

  function automatic logic [31:0] m_read(input int a);
    for (int n = 0; n < 8; n++) begin
      if (a == 'h420 + 8*n) return m_cnt[n];
      if (a == 'h220 + 8*n) return {24'd0, m_sel[n]};
    end
    case (a)
      'h500:        return {31'd0, m_gen};
      'h508, 'h50C: return {24'd0, m_en};
      'h510, 'h514: return {24'd0, m_ie};
      'h718:        return {24'd0, m_link};
      'h740:        return {24'd0, m_ovf};
      'h96C:        return {24'd0, m_tog};
      default:      return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < 8; n++) begin m_cnt[n] = 0; m_sel[n] = 0; end
      m_en = 0; m_ie = 0; m_link = 0; m_tog = 0; m_ovf = 0; m_gen = 0;
      m_rv = 0; m_rd = 0;
    end else begin
      logic [31:0] nc [8];
      logic [7:0]  fl;
      bit          cy, wrq, clr;
      int          a;
      a   = int'(bus_addr);
      wrq = bus_valid && bus_write;
      m_rv = bus_valid && !bus_write;
      m_rd = m_rv ? m_read(a) : 32'd0;
      clr = wrq && a == 'h500 && bus_wdata[1];
      cy = 0; fl = 0;
      for (int n = 0; n < 8; n++) begin
        int s; bit h, src, incr, w; logic [32:0] sum;
        s = int'(m_sel[n]);
        h = (s == 1) || (s >= 'h20 && s <= 'h25 && ev_in[s - 'h20]);
        src = ((n % 2) == 1 && m_link[n]) ? cy : h;
        incr = m_gen && m_en[n] && src;
        w = wrq && a == 'h420 + 8*n;
        sum = {1'b0, m_cnt[n]} + 33'd1;
        cy = 0;
        if (clr) nc[n] = 0;
        else if (w) nc[n] = bus_wdata;
        else if (incr) begin
          nc[n] = sum[31:0];
          cy = sum[32];
          if (sum[32] || (m_tog[n] && sum[31] != m_cnt[n][31])) fl[n] = 1;
        end else nc[n] = m_cnt[n];
      end
      if (wrq) begin
        for (int n = 0; n < 8; n++) if (a == 'h220 + 8*n) m_sel[n] = bus_wdata[7:0];
        if (a == 'h500) m_gen = bus_wdata[0];
        if (a == 'h508) m_en = m_en | bus_wdata[7:0];
        if (a == 'h50C) m_en = m_en & ~bus_wdata[7:0];
        if (a == 'h510) m_ie = m_ie | bus_wdata[7:0];
        if (a == 'h514) m_ie = m_ie & ~bus_wdata[7:0];
        if (a == 'h718) m_link = bus_wdata[7:0];
        if (a == 'h96C) m_tog = bus_wdata[7:0];
        if (a == 'h740) m_ovf = m_ovf & ~bus_wdata[7:0];
      end
      m_ovf = clr ? 8'd0 : (m_ovf | fl);
      for (int n = 0; n < 8; n++) m_cnt[n] = nc[n];
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(bus_ready == 1'b1, "ready", 32'(bus_ready), 32'd1);
      check(bus_rvalid == m_rv, "rvalid", 32'(bus_rvalid), 32'(m_rv));
      if (m_rv) check(bus_rdata == m_rd, "rdata", bus_rdata, m_rd);
      check(irq == |(m_ovf & m_ie), "irq", 32'(irq), 32'(|(m_ovf & m_ie)));
    end
  end

  task automatic idle_cycle();
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    ev_in = 6'($urandom);
  endtask
  task automatic reg_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 12'(a); bus_wdata = d;
    ev_in = 6'($urandom);
  endtask
  task automatic reg_rd(input int a);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = 12'(a); bus_wdata = 0;
    ev_in = 6'($urandom);
  endtask
  task automatic run(input int cyc);
    for (int i = 0; i < cyc; i++) idle_cycle();
  endtask
  task automatic read_all();
    for (int n = 0; n < 8; n++) begin
      reg_rd('h420 + 8*n); reg_rd('h220 + 8*n); reg_rd('h120 + 8*n);
    end
    reg_rd('h500); reg_rd('h508); reg_rd('h50C); reg_rd('h510); reg_rd('h514);
    reg_rd('h718); reg_rd('h740); reg_rd('h96C); reg_rd('h004); reg_rd('h424);
    reg_rd('hFFC);
    idle_cycle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    cur_req = "R1"; read_all();
    // R2: selector decode under random pulses
    cur_req = "R2";
    reg_wr('h220, 'h20); reg_wr('h228, 'h01); reg_wr('h230, 'h25); reg_wr('h238, 'h00);
    reg_wr('h240, 'h123); reg_wr('h248, 'h07); reg_wr('h250, 'h24); reg_wr('h258, 'h21);
    reg_wr('h508, 'hFF); reg_wr('h500, 1);
    run(40); read_all();
    // R3: per-counter and global gating
    cur_req = "R3";
    reg_wr('h50C, 'h0A); run(20); read_all();
    reg_wr('h500, 0); run(20); read_all();
    reg_wr('h508, 'h0A); reg_wr('h500, 1); run(5);
    // R4: preload while counting, read back
    cur_req = "R4";
    reg_wr('h428, 'h1234_5678); reg_rd('h428); reg_rd('h428); run(3); reg_rd('h428);
    reg_wr('h120, 'hFFFF_FFFF); read_all();
    // R5/R6: wrap flag, interrupt, write-one-to-clear
    cur_req = "R5";
    reg_wr('h240, 'h01); reg_wr('h440, 'hFFFF_FFFD); run(6); read_all();
    cur_req = "R6";
    reg_wr('h510, 'h10); run(3); reg_rd('h510);
    reg_wr('h740, 'h10); run(2);
    reg_wr('h440, 'hFFFF_FFFF); reg_wr('h740, 'h10); run(2); read_all();
    reg_wr('h514, 'h10); run(2); reg_wr('h740, 'hFF);
    // R7: linked pair 0/1, even link bit 0 is ignored
    cur_req = "R7";
    reg_wr('h220, 'h01); reg_wr('h718, 'h03);
    reg_wr('h420, 'hFFFF_FFF0); reg_wr('h428, 5); run(30); read_all();
    // R8: odd half wrap
    cur_req = "R8";
    reg_wr('h510, 'h03); reg_wr('h428, 'hFFFF_FFFF); reg_wr('h420, 'hFFFF_FFF8);
    run(12); read_all(); reg_wr('h740, 'hFF); reg_wr('h514, 'hFF); reg_wr('h718, 0);
    // R9: bit-31 toggle mode against plain mode
    cur_req = "R9";
    reg_wr('h250, 'h01); reg_wr('h258, 'h01); reg_wr('h96C, 'h40); reg_wr('h510, 'hC0);
    reg_wr('h450, 'h7FFF_FFFC); reg_wr('h458, 'h7FFF_FFFC); run(8); read_all();
    reg_wr('h740, 'hFF); reg_wr('h450, 'hFFFF_FFFD); run(6); read_all();
    // R10: unit reset bit
    cur_req = "R10";
    reg_wr('h500, 3); read_all(); run(10); read_all();
    reg_wr('h500, 2); run(5); read_all();
    // R11: idle bus and unmapped space
    cur_req = "R11";
    reg_wr('h004, 'hFFFF_FFFF); reg_rd('h004); reg_rd('h45C); reg_rd('h460); run(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule